// File: doc/BRIEF.md
# UART Loop and Single-Wire Pin Router

This block sits between a UART's shift logic and the two serial pads, one for transmit and one for receive. It holds one 8-bit serial control register, which a simple write strobe and a read-data bus give access to. From that register and from the enable, direction and GPIO inputs it decides where the receiver's serial input comes from and how each pad is driven. Each pad is shown as a separate output value and output enable, so the pad ring builds the tri-state buffer. The routing path has no registers. Pad drives and the receiver input follow their inputs in the same cycle.

Three routings are supported. In normal mode the transmitter drives the transmit pad and the receiver listens to the receive pad. In internal loopback the receiver hears the transmitter directly, and no pad is involved. In single-wire half-duplex mode the receiver listens to the transmit pad. When the UART is not using a pad, that pad works as a general-purpose output. An open-drain option makes every pad output drive low only, and it applies to UART and GPIO use alike. Frame-format, parity and wake-up bits are stored here and passed on to the UART core unchanged.

Top module: `uart_pin_mux`

## Requirements
- R1: After reset every control register bit is 0, and `reg_rdata` reads 0x00.
- R2: A write (`reg_wr` high at a clock edge) loads `reg_wdata` in any mode, and `reg_rdata` returns it from the next cycle on. Bit 7 is loop, bit 6 is open-drain, bit 5 is receive-from-pad. Bits 4..0 appear on `cfg_char9`, `cfg_wake_addr`, `cfg_idle_long`, `cfg_par_en` and `cfg_par_odd`, in that order from bit 4 down.
- R3: With loop (bit 7) clear, `rx_serial` follows `rxd_pin_in`. If `tx_enable` is high, the transmit pad drives `tx_serial` with its enable high.
- R4: With loop clear, a pad that the UART is not using falls back to GPIO: output enable = its direction input, value = its GPIO output. The transmit pad is unused when `tx_enable` is low, and the receive pad is unused when `rx_enable` is low. When `rx_enable` is high, the receive pad's enable is low.
- R5: With loop set, both enables high and bit 5 clear, `rx_serial` equals `tx_serial` and ignores both pad inputs.
- R6: With loop set, both enables high and bit 5 set, `rx_serial` equals `txd_pin_in`.
- R7: With loop set, the receive pad is always GPIO: enable = `rxd_dir`, value = `rxd_gpio_out`.
- R8: With loop set, both enables high and `txd_dir` high, the transmit pad drives `tx_serial`.
- R9: With loop set, both enables high and `txd_dir` low, the transmit pad drives high if bit 5 is clear. If bit 5 is set, the pad is released (enable low).
- R10: With open-drain (bit 6) set, a pad's enable is high only when its routed value is 0, and its value is then 0. A routed high releases the pad. Pad values matter only while their enable is high.
- R11: With loop set but `tx_enable` or `rx_enable` low, `rx_serial` is held at 1, and the transmit pad falls back to GPIO as in R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register contents |
| cfg_char9 | output | 1 | Stored character-length bit (bit 4) |
| cfg_wake_addr | output | 1 | Stored wake-up method bit (bit 3) |
| cfg_idle_long | output | 1 | Stored idle-line type bit (bit 2) |
| cfg_par_en | output | 1 | Stored parity enable bit (bit 1) |
| cfg_par_odd | output | 1 | Stored parity type bit (bit 0) |
| tx_serial | input | 1 | Transmitter serial output |
| tx_enable | input | 1 | Transmitter enabled |
| rx_enable | input | 1 | Receiver enabled |
| txd_dir | input | 1 | Transmit pad direction (1 = output) |
| txd_gpio_out | input | 1 | Transmit pad GPIO output value |
| rxd_dir | input | 1 | Receive pad direction (1 = output) |
| rxd_gpio_out | input | 1 | Receive pad GPIO output value |
| txd_pin_in | input | 1 | Transmit pad input level |
| rxd_pin_in | input | 1 | Receive pad input level |
| rx_serial | output | 1 | Receiver serial input |
| txd_out | output | 1 | Transmit pad output value |
| txd_oe | output | 1 | Transmit pad output enable |
| rxd_out | output | 1 | Receive pad output value |
| rxd_oe | output | 1 | Receive pad output enable |

## Verification
The bench sweeps every combination of loop, open-drain, receive-source, both enables and both direction bits against every data and pad-level pattern. This exposes a router that mixes up the two loop sources: such a router would pass pad noise through in internal loopback or ignore the transmit pad in single-wire mode. The checks on transmit direction clear cover both receive sources. A design that always idles high would contend with the far end in single-wire mode, and one that always releases would leave the line floating in loopback. Vectors with one enable low catch a receiver left connected to a stale source. Open-drain vectors with GPIO-owned pads catch a conversion applied only to UART traffic, which would drive the line high.

// File: rtl/upm_pkg.sv
// Package: shared types and constants for the UART pin router.
// Assumes the control register bit order below is what the UART core decodes.
package upm_pkg;

    localparam int CTRL_W   = 8;
    localparam int NUM_PINS = 2;
    localparam int TXD_IDX  = 0;
    localparam int RXD_IDX  = 1;

    // Control register, bit 7 down to bit 0.
    typedef struct packed {
        logic loop_en;      // bit 7: loop / single-wire routing
        logic open_drain;   // bit 6: wired-OR pad outputs
        logic rx_from_pin;  // bit 5: loop receive source is the transmit pad
        logic char9;        // bit 4: passed to UART core
        logic wake_addr;    // bit 3: passed to UART core
        logic idle_long;    // bit 2: passed to UART core
        logic par_en;       // bit 1: passed to UART core
        logic par_odd;      // bit 0: passed to UART core
    } upm_ctrl_t;

    // Pad drive before the open-drain stage.
    typedef struct packed {
        logic val;
        logic oe;
    } pin_drv_t;

endpackage

// File: rtl/upm_ctrl_reg.sv
// Module: upm_ctrl_reg
// Holds the serial control register. It is writable in every mode and clears on reset.
// Assumes a single-cycle write strobe and a synchronous active-low reset.
module upm_ctrl_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);

    // Register update: clear on reset, load on write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (wr_en)
            q <= wdata;
    end

    AST_REG_RESET: assert property (@(posedge clk) !rst_n |=> (q == '0)); // R1
    AST_REG_LOAD:  assert property (@(posedge clk) disable iff (!rst_n) wr_en |=> (q == $past(wdata))); // R2
    AST_REG_HOLD:  assert property (@(posedge clk) disable iff (!rst_n) !wr_en |=> $stable(q)); // R2

endmodule

// File: rtl/upm_route.sv
// Module: upm_route
// Selects the receiver source and the drive of both pads before open-drain conversion.
// Assumes all inputs are synchronous to clk. The logic is purely combinational;
// clk and rst_n serve the assertions only.
module upm_route
    import upm_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     loop_en,
    input  logic     rx_from_pin,
    input  logic     tx_serial,
    input  logic     tx_enable,
    input  logic     rx_enable,
    input  logic     txd_dir,
    input  logic     txd_gpio_out,
    input  logic     rxd_dir,
    input  logic     rxd_gpio_out,
    input  logic     txd_pin_in,
    input  logic     rxd_pin_in,
    output logic     rx_serial,
    output pin_drv_t txd_raw,
    output pin_drv_t rxd_raw
);

    logic loop_live;
    logic txd_gpio_owned;
    logic rxd_gpio_owned;

    // Mode decode: loop routing needs both directions of the UART enabled.
    always_comb begin
        loop_live      = loop_en && tx_enable && rx_enable;
        txd_gpio_owned = loop_en ? !loop_live : !tx_enable;
        rxd_gpio_owned = loop_en || !rx_enable;
    end

    // Receiver source selection.
    always_comb begin
        if (!loop_en)
            rx_serial = rxd_pin_in;
        else if (!loop_live)
            rx_serial = 1'b1;
        else if (rx_from_pin)
            rx_serial = txd_pin_in;
        else
            rx_serial = tx_serial;
    end

    // Transmit pad drive: UART waveform, idle high, released, or GPIO.
    always_comb begin
        if (txd_gpio_owned) begin
            txd_raw.val = txd_gpio_out;
            txd_raw.oe  = txd_dir;
        end else if (!loop_en || txd_dir) begin
            txd_raw.val = tx_serial;
            txd_raw.oe  = 1'b1;
        end else if (rx_from_pin) begin
            txd_raw.val = 1'b0;
            txd_raw.oe  = 1'b0;
        end else begin
            txd_raw.val = 1'b1;
            txd_raw.oe  = 1'b1;
        end
    end

    // Receive pad drive: GPIO when the receiver is not listening to it.
    always_comb begin
        if (rxd_gpio_owned) begin
            rxd_raw.val = rxd_gpio_out;
            rxd_raw.oe  = rxd_dir;
        end else begin
            rxd_raw.val = 1'b0;
            rxd_raw.oe  = 1'b0;
        end
    end

    AST_RX_IDLE_HELD:   assert property (@(posedge clk) disable iff (!rst_n) (loop_en && !(tx_enable && rx_enable)) |-> rx_serial); // R11
    AST_RX_INTERNAL:    assert property (@(posedge clk) disable iff (!rst_n) (loop_en && tx_enable && rx_enable && !rx_from_pin) |-> (rx_serial == tx_serial)); // R5
    AST_RX_SINGLE_WIRE: assert property (@(posedge clk) disable iff (!rst_n) (loop_en && tx_enable && rx_enable && rx_from_pin) |-> (rx_serial == txd_pin_in)); // R6
    AST_LOOP_RXD_GPIO:  assert property (@(posedge clk) disable iff (!rst_n) loop_en |-> (rxd_raw.oe == rxd_dir)); // R7
    AST_NORMAL_RX_PAD:  assert property (@(posedge clk) disable iff (!rst_n) (!loop_en && rx_enable) |-> !rxd_raw.oe); // R4

endmodule

// File: rtl/upm_pin_drive.sv
// Module: upm_pin_drive
// Final pad stage: passes the routed drive through, or turns it into open-drain.
// Assumes the pad ring builds the tri-state buffer from pin_val and pin_oe.
module upm_pin_drive (
    input  logic clk,
    input  logic rst_n,
    input  logic open_drain,
    input  logic raw_val,
    input  logic raw_oe,
    output logic pin_val,
    output logic pin_oe
);

    // Open-drain conversion: drive lows only, release for highs.
    always_comb begin
        if (open_drain) begin
            pin_val = 1'b0;
            pin_oe  = raw_oe && !raw_val;
        end else begin
            pin_val = raw_val;
            pin_oe  = raw_oe;
        end
    end

    AST_OD_LOW_ONLY: assert property (@(posedge clk) disable iff (!rst_n) (open_drain && pin_oe) |-> !pin_val); // R10
    AST_OD_RELEASE:  assert property (@(posedge clk) disable iff (!rst_n) (open_drain && raw_val) |-> !pin_oe); // R10

endmodule

// File: rtl/uart_pin_mux.sv
// Module: uart_pin_mux
// Top of the UART pin router: control register, source/drive routing and
// one open-drain stage per pad.
// Assumes a single control register with no address decode.
module uart_pin_mux
    import upm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [CTRL_W-1:0] reg_wdata,
    output logic [CTRL_W-1:0] reg_rdata,
    output logic              cfg_char9,
    output logic              cfg_wake_addr,
    output logic              cfg_idle_long,
    output logic              cfg_par_en,
    output logic              cfg_par_odd,
    input  logic              tx_serial,
    input  logic              tx_enable,
    input  logic              rx_enable,
    input  logic              txd_dir,
    input  logic              txd_gpio_out,
    input  logic              rxd_dir,
    input  logic              rxd_gpio_out,
    input  logic              txd_pin_in,
    input  logic              rxd_pin_in,
    output logic              rx_serial,
    output logic              txd_out,
    output logic              txd_oe,
    output logic              rxd_out,
    output logic              rxd_oe
);

    logic [CTRL_W-1:0]   ctrl_q;
    upm_ctrl_t           ctrl;
    pin_drv_t            txd_raw;
    pin_drv_t            rxd_raw;
    logic [NUM_PINS-1:0] raw_val;
    logic [NUM_PINS-1:0] raw_oe;
    logic [NUM_PINS-1:0] pad_val;
    logic [NUM_PINS-1:0] pad_oe;

    upm_ctrl_reg #(.W(CTRL_W)) u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (reg_wr),
        .wdata (reg_wdata),
        .q     (ctrl_q)
    );

    // Field view of the register, read-back and pass-through of core bits.
    always_comb begin
        ctrl          = upm_ctrl_t'(ctrl_q);
        reg_rdata     = ctrl_q;
        cfg_char9     = ctrl.char9;
        cfg_wake_addr = ctrl.wake_addr;
        cfg_idle_long = ctrl.idle_long;
        cfg_par_en    = ctrl.par_en;
        cfg_par_odd   = ctrl.par_odd;
    end

    upm_route u_route (
        .clk          (clk),
        .rst_n        (rst_n),
        .loop_en      (ctrl.loop_en),
        .rx_from_pin  (ctrl.rx_from_pin),
        .tx_serial    (tx_serial),
        .tx_enable    (tx_enable),
        .rx_enable    (rx_enable),
        .txd_dir      (txd_dir),
        .txd_gpio_out (txd_gpio_out),
        .rxd_dir      (rxd_dir),
        .rxd_gpio_out (rxd_gpio_out),
        .txd_pin_in   (txd_pin_in),
        .rxd_pin_in   (rxd_pin_in),
        .rx_serial    (rx_serial),
        .txd_raw      (txd_raw),
        .rxd_raw      (rxd_raw)
    );

    // Gather routed drives into per-pad vectors.
    always_comb begin
        raw_val[TXD_IDX] = txd_raw.val;
        raw_oe[TXD_IDX]  = txd_raw.oe;
        raw_val[RXD_IDX] = rxd_raw.val;
        raw_oe[RXD_IDX]  = rxd_raw.oe;
    end

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pad
        upm_pin_drive u_drv (
            .clk        (clk),
            .rst_n      (rst_n),
            .open_drain (ctrl.open_drain),
            .raw_val    (raw_val[p]),
            .raw_oe     (raw_oe[p]),
            .pin_val    (pad_val[p]),
            .pin_oe     (pad_oe[p])
        );
    end

    // Pad outputs.
    always_comb begin
        txd_out = pad_val[TXD_IDX];
        txd_oe  = pad_oe[TXD_IDX];
        rxd_out = pad_val[RXD_IDX];
        rxd_oe  = pad_oe[RXD_IDX];
    end

endmodule

// File: tb/uart_pin_mux_bench.sv
`timescale 1ns/1ps
module uart_pin_mux_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       cfg_char9, cfg_wake_addr, cfg_idle_long, cfg_par_en, cfg_par_odd;
    logic       tx_serial = 1'b1, tx_enable = 1'b0, rx_enable = 1'b0;
    logic       txd_dir = 1'b0, txd_gpio_out = 1'b0, rxd_dir = 1'b0, rxd_gpio_out = 1'b0;
    logic       txd_pin_in = 1'b1, rxd_pin_in = 1'b1;
    logic       rx_serial, txd_out, txd_oe, rxd_out, rxd_oe;

    int vectors = 0;
    int miscompares = 0;
    logic [7:0] shadow = 8'h00;

    typedef struct {
        logic       rx, tv, toe, rv, roe;
        logic [7:0] rdata;
        string      rx_tag, txd_tag, rxd_tag, reg_tag;
    } exp_t;

    exp_t sb[$];

    always #4 clk = ~clk;

    uart_pin_mux u_uart_pin_mux (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .cfg_char9(cfg_char9), .cfg_wake_addr(cfg_wake_addr), .cfg_idle_long(cfg_idle_long),
        .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
        .tx_serial(tx_serial), .tx_enable(tx_enable), .rx_enable(rx_enable),
        .txd_dir(txd_dir), .txd_gpio_out(txd_gpio_out), .rxd_dir(rxd_dir), .rxd_gpio_out(rxd_gpio_out),
        .txd_pin_in(txd_pin_in), .rxd_pin_in(rxd_pin_in),
        .rx_serial(rx_serial), .txd_out(txd_out), .txd_oe(txd_oe), .rxd_out(rxd_out), .rxd_oe(rxd_oe)
    );

    // Reference model built from the requirements.
    function automatic exp_t model(input logic [7:0] r, input string reg_tag);
        exp_t e;
        logic lp, od, src, both;
        lp = r[7]; od = r[6]; src = r[5];
        both = tx_enable && rx_enable;
        e.rdata = r;
        e.reg_tag = reg_tag;
        // receiver input: R3, R5, R6, R11
        if (!lp) begin e.rx = rxd_pin_in; e.rx_tag = "R3"; end
        else if (!both) begin e.rx = 1'b1; e.rx_tag = "R11"; end
        else if (src) begin e.rx = txd_pin_in; e.rx_tag = "R6"; end
        else begin e.rx = tx_serial; e.rx_tag = "R5"; end
        // transmit pad: R3, R4, R8, R9, R11
        if (!lp && tx_enable) begin e.tv = tx_serial; e.toe = 1'b1; e.txd_tag = "R3"; end
        else if (!lp) begin e.tv = txd_gpio_out; e.toe = txd_dir; e.txd_tag = "R4"; end
        else if (!both) begin e.tv = txd_gpio_out; e.toe = txd_dir; e.txd_tag = "R11"; end
        else if (txd_dir) begin e.tv = tx_serial; e.toe = 1'b1; e.txd_tag = "R8"; end
        else if (src) begin e.tv = 1'b0; e.toe = 1'b0; e.txd_tag = "R9"; end
        else begin e.tv = 1'b1; e.toe = 1'b1; e.txd_tag = "R9"; end
        // receive pad: R4, R7
        if (!lp && rx_enable) begin e.rv = 1'b0; e.roe = 1'b0; e.rxd_tag = "R4"; end
        else begin e.rv = rxd_gpio_out; e.roe = rxd_dir; e.rxd_tag = lp ? "R7" : "R4"; end
        // open drain: R10
        if (od) begin
            e.toe = e.toe && !e.tv; e.tv = 1'b0;
            e.roe = e.roe && !e.rv; e.rv = 1'b0;
            e.txd_tag = "R10"; e.rxd_tag = "R10";
        end
        return e;
    endfunction

    task automatic fail(input string tag, input string what, input int act, input int exp);
        $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    endtask

    // Monitor: pop one expected item per cycle and compare.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb.size() > 0) begin
                exp_t e;
                bit bad;
                e = sb.pop_front();
                bad = 1'b0;
                vectors++;
                if (rx_serial !== e.rx) begin bad = 1; fail(e.rx_tag, "rx_serial", rx_serial, e.rx); end
                if (txd_oe !== e.toe) begin bad = 1; fail(e.txd_tag, "txd_oe", txd_oe, e.toe); end
                if (e.toe && txd_out !== e.tv) begin bad = 1; fail(e.txd_tag, "txd_out", txd_out, e.tv); end
                if (rxd_oe !== e.roe) begin bad = 1; fail(e.rxd_tag, "rxd_oe", rxd_oe, e.roe); end
                if (e.roe && rxd_out !== e.rv) begin bad = 1; fail(e.rxd_tag, "rxd_out", rxd_out, e.rv); end
                if (reg_rdata !== e.rdata) begin bad = 1; fail(e.reg_tag, "reg_rdata", reg_rdata, e.rdata); end
                if ({cfg_char9, cfg_wake_addr, cfg_idle_long, cfg_par_en, cfg_par_odd} !== e.rdata[4:0]) begin
                    bad = 1;
                    fail("R2", "cfg bits", {cfg_char9, cfg_wake_addr, cfg_idle_long, cfg_par_en, cfg_par_odd}, e.rdata[4:0]);
                end
                if (bad) miscompares++;
            end
        end
    end

    // Driver: register write (R2).
    task automatic write_reg(input logic [7:0] v);
        @(negedge clk);
        reg_wr = 1'b1;
        reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
        reg_wdata = ~v;
        shadow = v;
    endtask

    // Driver: apply one input pattern and push its expectation.
    task automatic apply(input logic [3:0] ctl, input logic [4:0] dat, input string reg_tag);
        @(negedge clk);
        {tx_enable, rx_enable, txd_dir, rxd_dir} = ctl;
        {tx_serial, txd_gpio_out, rxd_gpio_out, txd_pin_in, rxd_pin_in} = dat;
        sb.push_back(model(shadow, reg_tag));
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        $display("FAIL watchdog R1..all actual=hung expected=done");
        miscompares++;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state, several input patterns before any write
        for (int k = 0; k < 16; k++) apply(4'(k), 5'(k * 3 + 1), "R1");
        // Full sweep of mode bits, enables, directions and data/pad levels
        for (int m = 0; m < 8; m++) begin
            write_reg({3'(m), 5'(m * 7 + 3)});
            for (int c = 0; c < 16; c++)
                for (int d = 0; d < 32; d++)
                    apply(4'(c), 5'(d), "R2");
        end
        // R2: write while a loop mode is active, with traffic present
        write_reg(8'hA5);
        apply(4'hF, 5'h15, "R2");
        write_reg(8'h1F);
        apply(4'hC, 5'h0A, "R2");
        while (sb.size() > 0) @(posedge clk);
        repeat (2) @(posedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule